// File: doc/BRIEF.md
# Mode-Selectable Operand Forwarding and Stall Control

This block decides, for the instruction sitting in the decode stage of a five-stage in-order integer pipeline, whether it may move on into execute and, if so, where each of its two ALU operands must come from. It compares the two source register numbers of the decoding instruction with the destination, write enable and load flag of the instructions now in execute and in memory access. When an operand cannot yet be supplied, it freezes the program counter and the fetch/decode register and turns the decode/execute entry into a bubble. The rule is re-applied in every frozen cycle, so one dependence can cost one or two cycles.

A two-bit mode input sets which bypass paths exist: none, both, only the one-cycle path from the execute/memory register, or only the two-cycle path from the memory/writeback register. Both the stall rule and the operand selects follow the mode. The register file writes early in a cycle and reads late, so a producer three or more instructions older never matters. The operand selects are registered, so they are valid while the instruction is in execute.

Top module: `hz_fwd_stall_unit`

## Requirements
- R1: Mode code 2'b00 (no bypass): a consumer right behind its producer is held 2 cycles, one with a single instruction between them is held 1 cycle, one that reads results of both preceding instructions is held 2 cycles, and both operand selects are always 2'b00.
- R2: Mode code 2'b01 (both paths): an ALU result reaches the very next instruction with no hold, any producer two instructions back is bypassed with no hold, and a load directly followed by its consumer costs exactly 1 hold cycle.
- R3: Mode code 2'b10 (one-cycle path only): an ALU result reaches the very next instruction with no hold, a dependence on the instruction two back costs 1 hold cycle, a load directly followed by its consumer costs 2 hold cycles, and the select 2'b01 never appears.
- R4: Mode code 2'b11 (two-cycle path only): a dependence two back is bypassed with no hold, an ALU or load result needed by the very next instruction costs 1 hold cycle, and the select 2'b10 never appears.
- R5: An operand select is 2'b00 for the register file, 2'b01 for the memory/writeback value and 2'b10 for the execute/memory value. It is presented in the cycle the instruction occupies execute, and 2'b11 never appears.
- R6: When the producers in execute and in memory access both write the register a source reads, the younger one (in execute) alone sets the hold and the select.
- R7: A source reading register 0 and a producer whose write enable is low never cause a hold or a bypass.
- R8: A producer three or more instructions older than the consumer causes neither a hold nor a bypass.
- R9: While holding, the stall and bubble outputs are high together, and the entry sent to execute has both selects 2'b00. The decision is made again in every held cycle.
- R10: While reset is asserted, both operand selects read 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the select registers |
| fwd_mode | input | 2 | Bypass mode: 00 none, 01 both, 10 one-cycle only, 11 two-cycle only |
| id_src_a | input | REG_W | First source register of the decoding instruction |
| id_src_b | input | REG_W | Second source register of the decoding instruction |
| ex_rd | input | REG_W | Destination register of the instruction in execute |
| ex_we | input | 1 | Register write enable of the instruction in execute |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_W | Destination register of the instruction in memory access |
| mem_we | input | 1 | Register write enable of the instruction in memory access |
| stall_front | output | 1 | Hold the program counter and fetch/decode register |
| bubble_idex | output | 1 | Load a bubble into the decode/execute register |
| ex_sel_a | output | 2 | Source select for ALU operand A of the instruction in execute |
| ex_sel_b | output | 2 | Source select for ALU operand B of the instruction in execute |

## Verification
The two functions that meet in one cycle are bypassing one operand and holding for the other. In the one-cycle-only mode, a consumer whose first operand comes from the ALU instruction just ahead and whose second comes from the one before it must hold even though its first operand could be bypassed. On the next cycle the first producer has moved to memory access, where it can no longer be bypassed, and that forces a second hold. The bench sweeps every mode against producer types, shared destinations, register 0 and both operand choices. It judges each instruction by its hold count and by the selects seen in its execute cycle, both predicted from a distance-legality table per mode.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    FWD_NONE = 2'b00,
    FWD_FULL = 2'b01,
    FWD_NEXT = 2'b10,
    FWD_TWO  = 2'b11
  } fwd_mode_e;

  typedef enum logic [1:0] {
    OP_RF    = 2'b00,
    OP_MEMWB = 2'b01,
    OP_EXMEM = 2'b10
  } op_src_e;

  // one-cycle path: from the execute/memory register into execute
  function automatic logic next_path_on(fwd_mode_e m);
    return (m == FWD_FULL) || (m == FWD_NEXT);
  endfunction

  // two-cycle path: from the memory/writeback register into execute
  function automatic logic two_path_on(fwd_mode_e m);
    return (m == FWD_FULL) || (m == FWD_TWO);
  endfunction

  // the younger producer hides the older one for the same source
  function automatic logic must_wait(fwd_mode_e m, logic hit_ex,
                                     logic ex_load, logic hit_mem);
    if (hit_ex) return ex_load || !next_path_on(m);
    return hit_mem && !two_path_on(m);
  endfunction

  function automatic op_src_e choose_src(fwd_mode_e m, logic hit_ex,
                                         logic hit_mem);
    if (hit_ex) return next_path_on(m) ? OP_EXMEM : OP_RF;
    if (hit_mem && two_path_on(m)) return OP_MEMWB;
    return OP_RF;
  endfunction

endpackage

// File: rtl/hz_src_check.sv
module hz_src_check
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fwd_mode_e        mode,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  output logic             hit_ex,
  output logic             hit_mem,
  output logic             blocks,
  output op_src_e          pick
);

  logic src_live;

  always_comb begin
    src_live = (src != '0);
    hit_ex   = src_live && ex_we && (ex_rd == src);
    hit_mem  = src_live && mem_we && (mem_rd == src);
    blocks   = must_wait(mode, hit_ex, ex_load, hit_mem);
    pick     = choose_src(mode, hit_ex, hit_mem);
  end

  // R7
  zero_src_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (!blocks && pick == OP_RF));

  // R2
  load_use_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src != '0 && ex_we && ex_load && ex_rd == src) |-> blocks);

  // R1
  none_mode_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FWD_NONE && (hit_ex || hit_mem)) |-> blocks);

endmodule

// File: rtl/hz_sel_stage.sv
module hz_sel_stage
  import hz_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bubble,
  input  logic [NSRC-1:0][1:0] pick_in,
  output logic [NSRC-1:0][1:0] sel_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (bubble) sel_q <= '0;
    else             sel_q <= pick_in;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_lane
    // R5
    sel_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[g] != 2'b11);
  end

endmodule

// File: rtl/hz_fwd_stall_unit.sv
module hz_fwd_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fwd_mode,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  output logic             stall_front,
  output logic             bubble_idex,
  output logic [1:0]       ex_sel_a,
  output logic [1:0]       ex_sel_b
);

  localparam int NSRC = 2;

  fwd_mode_e                  mode;
  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic [NSRC-1:0]            hit_ex_v;
  logic [NSRC-1:0]            hit_mem_v;
  logic [NSRC-1:0]            block_v;
  logic [NSRC-1:0][1:0]       pick_v;
  logic [NSRC-1:0][1:0]       sel_v;
  logic                       hold;

  assign mode    = fwd_mode_e'(fwd_mode);
  assign srcs[0] = id_src_a;
  assign srcs[1] = id_src_b;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    op_src_e pick_e;
    hz_src_check #(.REG_W(REG_W)) u_chk (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .src     (srcs[g]),
      .ex_rd   (ex_rd),
      .ex_we   (ex_we),
      .ex_load (ex_load),
      .mem_rd  (mem_rd),
      .mem_we  (mem_we),
      .hit_ex  (hit_ex_v[g]),
      .hit_mem (hit_mem_v[g]),
      .blocks  (block_v[g]),
      .pick    (pick_e)
    );
    assign pick_v[g] = pick_e;
  end

  assign hold        = |block_v;
  assign stall_front = hold;
  assign bubble_idex = hold;

  hz_sel_stage #(.NSRC(NSRC)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .bubble  (hold),
    .pick_in (pick_v),
    .sel_q   (sel_v)
  );

  assign ex_sel_a = sel_v[0];
  assign ex_sel_b = sel_v[1];

  // R9
  bubble_clears_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_front |=> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00));

  // R1
  none_mode_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mode == 2'b00) |=> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00));

  // R3
  next_mode_no_memwb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mode == 2'b10) |=> (ex_sel_a != 2'b01 && ex_sel_b != 2'b01));

  // R4
  two_mode_no_exmem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mode == 2'b11) |=> (ex_sel_a != 2'b10 && ex_sel_b != 2'b10));

  // R2
  full_alu_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mode == 2'b01 && !ex_load) |-> !stall_front);

endmodule

// File: tb/test_hz_fwd_stall_unit.sv
module test_hz_fwd_stall_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic [4:0] src_a, src_b, ex_rd, mem_rd;
  logic       ex_we, ex_load, mem_we;
  logic       stall, bub;
  logic [1:0] sel_a, sel_b;

  always #10 clk = ~clk;

  hz_fwd_stall_unit #(.REG_W(5)) i_hz_fwd_stall_unit (
    .clk(clk), .rst_n(rst_n), .fwd_mode(mode),
    .id_src_a(src_a), .id_src_b(src_b),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_we(mem_we),
    .stall_front(stall), .bubble_idex(bub),
    .ex_sel_a(sel_a), .ex_sel_b(sel_b)
  );

  typedef struct packed {
    logic [4:0] rd; logic [4:0] ra; logic [4:0] rb;
    logic we; logic ld; logic real_i; logic bub;
    logic [3:0] idx; logic [3:0] st;
  } ins_t;

  ins_t  id_s, ex_s, mem_s;
  ins_t  pr [8];
  int    e_t [8];
  int    exp_st [8];
  int    exp_a [8];
  int    exp_b [8];
  int    n, fp, cons_idx, cur_mode;
  int    errors = 0, checks = 0, cyc = 0;
  bit    done_flag = 0, group_done;
  string gtag, mtag;

  function automatic ins_t mk(int rd, int ra, int rb, bit we, bit ld, bit r);
    ins_t t;
    t.rd = 5'(rd); t.ra = 5'(ra); t.rb = 5'(rb);
    t.we = we; t.ld = ld; t.real_i = r; t.bub = 1'b0;
    t.idx = 4'd0; t.st = 4'd0;
    return t;
  endfunction

  // distance in execute-entry cycles at which a result is usable, per mode
  function automatic bit legal(int m, int d, bit ld);
    if (d >= 3) return 1'b1;
    if (d == 1) return ((m == 1) || (m == 2)) && !ld;
    if (d == 2) return (m == 1) || (m == 3);
    return 1'b0;
  endfunction

  function automatic int youngest(int i, logic [4:0] r);
    for (int j = i - 1; j >= 0; j--)
      if (r != 5'd0 && pr[j].we && pr[j].rd == r) return j;
    return -1;
  endfunction

  function automatic int code_of(int d);
    if (d == 1) return 2;
    if (d == 2) return 1;
    return 0;
  endfunction

  task automatic plan_group();
    for (int i = 0; i < n; i++) begin
      int ja, jb, cand;
      ja = youngest(i, pr[i].ra);
      jb = youngest(i, pr[i].rb);
      if (i == 0) cand = 0;
      else begin
        cand = e_t[i-1] + 1;
        for (int k = 0; k < 4; k++) begin
          bit ok;
          ok = 1'b1;
          if (ja >= 0 && !legal(cur_mode, cand - e_t[ja], pr[ja].ld)) ok = 1'b0;
          if (jb >= 0 && !legal(cur_mode, cand - e_t[jb], pr[jb].ld)) ok = 1'b0;
          if (!ok) cand++;
        end
      end
      e_t[i]    = cand;
      exp_st[i] = (i == 0) ? 0 : cand - e_t[i-1] - 1;
      exp_a[i]  = (ja >= 0) ? code_of(cand - e_t[ja]) : 0;
      exp_b[i]  = (jb >= 0) ? code_of(cand - e_t[jb]) : 0;
    end
  endtask

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (mode %0d)", tag, what, act, expv, cur_mode);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic ins_t fetch_next();
    ins_t t;
    if (fp < n) begin
      t = pr[fp]; t.idx = 4'(fp); fp++;
    end else t = mk(0, 0, 0, 0, 0, 0);
    return t;
  endfunction

  task automatic step();
    string tg;
    @(negedge clk);
    src_a = id_s.ra; src_b = id_s.rb;
    ex_rd = ex_s.rd; ex_we = ex_s.we; ex_load = ex_s.ld;
    mem_rd = mem_s.rd; mem_we = mem_s.we;
    if (ex_s.real_i) begin
      tg = (int'(ex_s.idx) == cons_idx) ? gtag : mtag;
      // R5: selects seen while the instruction is in execute
      check(sel_a == 2'(exp_a[ex_s.idx]), tg, "operand A select", sel_a, exp_a[ex_s.idx]);
      check(sel_b == 2'(exp_b[ex_s.idx]), tg, "operand B select", sel_b, exp_b[ex_s.idx]);
      check(int'(ex_s.st) == exp_st[ex_s.idx], tg, "hold cycles", ex_s.st, exp_st[ex_s.idx]);
      if (int'(ex_s.idx) == n - 1) group_done = 1'b1;
    end else if (ex_s.bub) begin
      check(sel_a == 2'b00 && sel_b == 2'b00, "R9", "bubble selects", {sel_a, sel_b}, 0);
    end
    #1;
    check(bub === stall, "R9", "bubble vs stall", bub, stall);
    mem_s = ex_s;
    if (stall) begin
      ex_s = mk(0, 0, 0, 0, 0, 0); ex_s.bub = 1'b1;
      id_s.st = id_s.st + 4'd1;
    end else begin
      ex_s = id_s; ex_s.bub = 1'b0;
      id_s = fetch_next();
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      report();
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'b01;
    src_a = 5'd5; src_b = 5'd6; ex_rd = 5'd5; ex_we = 1'b1; ex_load = 1'b0;
    mem_rd = 5'd6; mem_we = 1'b1;
    n = 0; fp = 0; cons_idx = -1; cur_mode = 1;
    id_s = mk(0, 0, 0, 0, 0, 0); ex_s = id_s; mem_s = id_s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: selects stay cleared during reset even with hazards present
    check(sel_a == 2'b00, "R10", "reset select A", sel_a, 0);
    check(sel_b == 2'b00, "R10", "reset select B", sel_b, 0);
    src_a = 0; src_b = 0; ex_we = 0; mem_we = 0; ex_rd = 0; mem_rd = 0;
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++)
      for (int t0 = 0; t0 < 3; t0++)
        for (int t1 = 0; t1 < 3; t1++)
          for (int xs = 0; xs < 3; xs++)
            for (int gap = 0; gap < 2; gap++)
              for (int ca = 0; ca < 4; ca++)
                for (int cb = 0; cb < 4; cb++) begin
                  int x, y, ra, rb;
                  cur_mode = m;
                  mode = 2'(m);
                  x = (xs == 2) ? 0 : 5;
                  y = (xs == 2) ? 0 : ((xs == 1) ? 5 : 6);
                  ra = (ca == 0) ? x : (ca == 1) ? y : (ca == 2) ? 17 : 0;
                  rb = (cb == 0) ? x : (cb == 1) ? y : (cb == 2) ? 17 : 0;
                  for (int k = 0; k < 3; k++) pr[k] = mk(0, 0, 0, 0, 0, 0);
                  pr[3] = mk(x, 20, 21, t0 != 0, t0 == 2, 1);
                  pr[4] = mk(y, 22, 23, t1 != 0, t1 == 2, 1);
                  n = 5;
                  if (gap == 1) begin pr[5] = mk(0, 0, 0, 0, 0, 0); n = 6; end
                  pr[n] = mk(0, ra, rb, 1, 0, 1);
                  cons_idx = n;
                  n = n + 1;
                  mtag = (m == 0) ? "R1" : (m == 1) ? "R2" : (m == 2) ? "R3" : "R4";
                  if (xs == 1 && (ca < 2 || cb < 2)) gtag = "R6";
                  else if (xs == 2 || ca == 3 || cb == 3) gtag = "R7";
                  else if ((t0 == 0 && (ca == 0 || cb == 0)) || (t1 == 0 && (ca == 1 || cb == 1))) gtag = "R7";
                  else if (gap == 1 && (ca == 0 || cb == 0)) gtag = "R8";
                  else gtag = mtag;
                  fp = 0;
                  plan_group();
                  group_done = 1'b0;
                  while (!group_done) step();
                end
    repeat (3) step();
    report();
  end

endmodule